// File: doc/BRIEF.md
# Chained Multi-Array Readout Sequencer

This block sequences the readout of several identical linear photodiode arrays mounted end to end so that they behave as one long line sensor. All arrays integrate together, but only one may shift its pixels out at any moment. The sequencer starts the first array when a frame is requested. It then lets each array's end-of-scan flag start its successor. It also drives a one-hot select for an external analog switch, so that only the array being scanned reaches the shared video line.

The shared readout clocks arrive as two synchronous level inputs: a first phase and a second phase. The first phase's falling edge is where an array reports end-of-scan. The second phase's rising edge is where one element appears on the video line. For every such element the sequencer emits a strobe with a frame-wide pixel index. The index is the array number times the elements per array, plus the element's position inside its array. After the last element of the last array it pulses frame-done and returns to idle. The number of arrays taking part is an input, latched when the frame starts.

Top module: `chained_scan_seq`

## Requirements
- R1: After reset, start_o, sel_o, pix_valid_o and frame_done_o are all zero.
- R2: A frame_start_i pulse while idle raises start_o[0] and sets sel_o to bit 0 only (value 1) in the next cycle. start_o[0] stays high until the cycle after the next rising edge of phi1_i, and then drops.
- R3: A frame_start_i pulse during a frame is ignored: start_o[0] stays low and sel_o keeps its value.
- R4: Each rising edge of phi2_i during a frame gives a one-cycle pix_valid_o pulse in the next cycle. pix_idx_o then equals array*ELEMS + local, where local counts from 0 in each array.
- R5: When eos_n_i of the selected array is low at a falling edge of phi1_i, the select stays put. It moves to the next array (sel_o shifted left by one bit) only on the following rising edge of phi2_i, after that last element is strobed.
- R6: For k >= 1, start_o[k] is high one cycle after eos_n_i[k-1] is low, but only during a frame and only when k is below the latched array count. Otherwise it is low.
- R7: sel_o is one-hot during a frame and all zero when idle.
- R8: frame_done_o pulses for one cycle, together with the strobe of the last element of the final array. sel_o is zero from that cycle on.
- R9: The array count is latched at frame start. A value of 0 is taken as 1, and a value above N_ARRAYS is taken as N_ARRAYS.
- R10: N_ARRAYS lies between 1 and 8. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame request, accepted only while idle |
| arr_cnt_i | input | CW | Number of arrays to read, latched at frame start |
| eos_n_i | input | N_ARRAYS | Active-low end-of-scan from each array |
| phi1_i | input | 1 | First readout clock phase (synchronous level) |
| phi2_i | input | 1 | Second readout clock phase (synchronous level) |
| start_o | output | N_ARRAYS | Active-high start pulse to each array |
| sel_o | output | N_ARRAYS | One-hot analog switch select |
| pix_valid_o | output | 1 | One-cycle strobe per element read out |
| pix_idx_o | output | IW | Frame-wide pixel index for the strobed element |
| frame_done_o | output | 1 | One-cycle pulse after the final element |

## Verification
On every cycle, assertions hold the select to one-hot or zero, keep it equal to the busy state, and forbid it from moving except on a second-phase rising edge. They also bound the pixel index, keep frame-done to a single cycle with the select cleared, and keep every chained start inside a frame. Only the bench's scenarios show the exact index sequence across array boundaries. They also show that the select holds at the end-of-scan edge and moves one element later, that start pulses stop at the array count, that count values are clamped, and that a request during a frame is ignored.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

   // Clamp a requested array count into the legal range 1..max_n.
   function automatic int unsigned clamp_count(input int unsigned req, input int unsigned max_n);
      if (req == 0)
         return 1;
      else if (req > max_n)
         return max_n;
      else
         return req;
   endfunction

endpackage

// File: rtl/seqr_edge_det.sv
module seqr_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lvl_q <= 1'b0;
      else
         lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
   assign fall_o = ~lvl_i & lvl_q;

endmodule

// File: rtl/seqr_chain_start.sv
module seqr_chain_start #(
   parameter int N_ARRAYS = 4,
   parameter int CW       = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                busy_i,
   input  logic [CW-1:0]       cnt_i,
   input  logic                st0_i,
   input  logic [N_ARRAYS-1:0] eos_n_i,
   input  logic [N_ARRAYS-1:0] sel_i,
   output logic [N_ARRAYS-1:0] start_o
);

   assign start_o[0] = st0_i;

   for (genvar k = 1; k < N_ARRAYS; k++) begin : g_link
      logic st_q;

      // R6: the inverted end-of-scan of array k-1 starts array k
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            st_q <= 1'b0;
         else
            st_q <= busy_i && (CW'(k) < cnt_i) && !eos_n_i[k-1];
      end

      assign start_o[k] = st_q;

      p_chain_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
         start_o[k] |-> (sel_i != '0));
   end

endmodule

// File: rtl/seqr_scan_ctrl.sv
module seqr_scan_ctrl
   import seqr_pkg::*;
#(
   parameter int N_ARRAYS = 4,
   parameter int ELEMS    = 64,
   parameter int CW       = 3,
   parameter int IW       = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_start_i,
   input  logic [CW-1:0]       cnt_i,
   input  logic [N_ARRAYS-1:0] eos_n_i,
   input  logic                rise1_i,
   input  logic                fall1_i,
   input  logic                rise2_i,
   output logic                busy_o,
   output logic [CW-1:0]       cnt_o,
   output logic                st0_o,
   output logic [N_ARRAYS-1:0] sel_o,
   output logic                pix_valid_o,
   output logic [IW-1:0]       pix_idx_o,
   output logic                done_o
);

   localparam int AW = (N_ARRAYS > 1) ? $clog2(N_ARRAYS) : 1;
   localparam int LW = (ELEMS > 1) ? $clog2(ELEMS) : 1;

   logic                busy_q, st0_q, eos_seen_q, valid_q, done_q;
   logic [AW-1:0]       cur_q;
   logic [LW-1:0]       lcnt_q;
   logic [CW-1:0]       cnt_q;
   logic [N_ARRAYS-1:0] sel_q;
   logic [IW-1:0]       idx_q;
   logic                accept, last_arr, eos_now;

   assign accept   = frame_start_i && !busy_q;
   assign last_arr = ((CW'(cur_q) + CW'(1)) == cnt_q);
   assign eos_now  = fall1_i && !eos_n_i[cur_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         st0_q      <= 1'b0;
         eos_seen_q <= 1'b0;
         valid_q    <= 1'b0;
         done_q     <= 1'b0;
         cur_q      <= '0;
         lcnt_q     <= '0;
         cnt_q      <= CW'(1);
         sel_q      <= '0;
         idx_q      <= '0;
      end else begin
         valid_q <= 1'b0;
         done_q  <= 1'b0;
         if (accept) begin
            busy_q     <= 1'b1;
            st0_q      <= 1'b1;
            eos_seen_q <= 1'b0;
            cur_q      <= '0;
            lcnt_q     <= '0;
            cnt_q      <= CW'(clamp_count(int'(cnt_i), N_ARRAYS));  // R9
            sel_q      <= N_ARRAYS'(1);
         end else if (busy_q) begin
            if (rise1_i)
               st0_q <= 1'b0;
            if (eos_now)
               eos_seen_q <= 1'b1;
            if (rise2_i) begin
               valid_q <= 1'b1;
               idx_q   <= IW'(cur_q) * IW'(ELEMS) + IW'(lcnt_q);  // R4
               if (eos_seen_q) begin
                  eos_seen_q <= 1'b0;
                  lcnt_q     <= '0;
                  if (last_arr) begin
                     busy_q <= 1'b0;
                     st0_q  <= 1'b0;
                     sel_q  <= '0;
                     done_q <= 1'b1;                               // R8
                  end else begin
                     cur_q <= cur_q + AW'(1);
                     sel_q <= sel_q << 1;                          // R5
                  end
               end else if (lcnt_q != LW'(ELEMS - 1)) begin
                  lcnt_q <= lcnt_q + LW'(1);
               end
            end
         end
      end
   end

   assign busy_o      = busy_q;
   assign cnt_o       = cnt_q;
   assign st0_o       = st0_q;
   assign sel_o       = sel_q;
   assign pix_valid_o = valid_q;
   assign pix_idx_o   = idx_q;
   assign done_o      = done_q;

   p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_q) && (busy_q == (sel_q != '0)));

   p_sel_moves_on_rise2_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !rise2_i) |=> $stable(sel_q));

   p_idx_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (idx_q < IW'(N_ARRAYS * ELEMS)));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (sel_q == '0) ##1 !done_q);

   p_busy_ignores_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && frame_start_i && !rise2_i) |=> $stable(cur_q));

endmodule

// File: rtl/chained_scan_seq.sv
module chained_scan_seq #(
   parameter  int N_ARRAYS = 4,
   parameter  int ELEMS    = 64,
   localparam int CW       = $clog2(N_ARRAYS + 1),
   localparam int IW       = $clog2(N_ARRAYS * ELEMS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_start_i,
   input  logic [CW-1:0]       arr_cnt_i,
   input  logic [N_ARRAYS-1:0] eos_n_i,
   input  logic                phi1_i,
   input  logic                phi2_i,
   output logic [N_ARRAYS-1:0] start_o,
   output logic [N_ARRAYS-1:0] sel_o,
   output logic                pix_valid_o,
   output logic [IW-1:0]       pix_idx_o,
   output logic                frame_done_o
);

   // R10: legal array count range
   if (N_ARRAYS < 1 || N_ARRAYS > 8) begin : g_bad_n
      $error("chained_scan_seq: N_ARRAYS must be 1..8");
   end
   if (ELEMS < 2) begin : g_bad_e
      $error("chained_scan_seq: ELEMS must be at least 2");
   end

   logic          rise1, fall1, rise2, fall2_unused;
   logic          busy, st0;
   logic [CW-1:0] cnt_l;

   seqr_edge_det u_phi1 (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (phi1_i),
      .rise_o (rise1),
      .fall_o (fall1)
   );

   seqr_edge_det u_phi2 (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (phi2_i),
      .rise_o (rise2),
      .fall_o (fall2_unused)
   );

   seqr_scan_ctrl #(
      .N_ARRAYS (N_ARRAYS),
      .ELEMS    (ELEMS),
      .CW       (CW),
      .IW       (IW)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (frame_start_i),
      .cnt_i         (arr_cnt_i),
      .eos_n_i       (eos_n_i),
      .rise1_i       (rise1),
      .fall1_i       (fall1),
      .rise2_i       (rise2),
      .busy_o        (busy),
      .cnt_o         (cnt_l),
      .st0_o         (st0),
      .sel_o         (sel_o),
      .pix_valid_o   (pix_valid_o),
      .pix_idx_o     (pix_idx_o),
      .done_o        (frame_done_o)
   );

   seqr_chain_start #(
      .N_ARRAYS (N_ARRAYS),
      .CW       (CW)
   ) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy_i  (busy),
      .cnt_i   (cnt_l),
      .st0_i   (st0),
      .eos_n_i (eos_n_i),
      .sel_i   (sel_o),
      .start_o (start_o)
   );

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (start_o[0] == 1'b0));

endmodule

// File: tb/chained_scan_seq_test.sv
module chained_scan_seq_test;

   localparam int N  = 5;
   localparam int E  = 3;
   localparam int CW = $clog2(N + 1);
   localparam int IW = $clog2(N * E + 1);

   // frame table: {requested count, expected arrays, poke frame_start mid-frame}
   localparam int NV = 5;
   localparam int VEC [NV][3] = '{
      '{1, 1, 0},
      '{5, 5, 1},
      '{3, 3, 0},
      '{0, 1, 0},
      '{7, 5, 1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start_i = 1'b0;
   logic [CW-1:0] arr_cnt_i = '0;
   logic [N-1:0]  eos_n_i = '1;
   logic          phi1_i = 1'b0;
   logic          phi2_i = 1'b0;
   logic [N-1:0]  start_o, sel_o;
   logic          pix_valid_o, frame_done_o;
   logic [IW-1:0] pix_idx_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   chained_scan_seq #(.N_ARRAYS(N), .ELEMS(E)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (frame_start_i),
      .arr_cnt_i     (arr_cnt_i),
      .eos_n_i       (eos_n_i),
      .phi1_i        (phi1_i),
      .phi2_i        (phi2_i),
      .start_o       (start_o),
      .sel_o         (sel_o),
      .pix_valid_o   (pix_valid_o),
      .pix_idx_o     (pix_idx_o),
      .frame_done_o  (frame_done_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // one element period of array k, element e
   task automatic element(input int k, input int e, input int cnt, input bit poke);
      bit last = (e == E - 1);
      step(); phi1_i = 1'b1;
      if (poke) frame_start_i = 1'b1;
      step();
      frame_start_i = 1'b0;
      if (k == 0 && e == 0)
         chk(start_o[0] == 1'b0, "R2 start0 drops after phi1 rise", int'(start_o[0]), 0);
      if (poke) begin
         chk(start_o[0] == 1'b0, "R3 start0 during frame", int'(start_o[0]), 0);
         chk(sel_o == N'(1 << k), "R3 sel kept", int'(sel_o), 1 << k);
      end
      phi1_i = 1'b0;
      if (last) eos_n_i[k] = 1'b0;
      step();
      chk(sel_o == N'(1 << k), "R5 sel held at eos edge", int'(sel_o), 1 << k);
      if (last && k + 1 < N)
         chk(start_o[k+1] == (k + 1 < cnt), "R6 chained start", int'(start_o[k+1]),
             int'(k + 1 < cnt));
      phi2_i = 1'b1;
      step();
      chk(pix_valid_o == 1'b1, "R4 strobe", int'(pix_valid_o), 1);
      chk(int'(pix_idx_o) == k * E + e, "R4 index", int'(pix_idx_o), k * E + e);
      chk(frame_done_o == (last && k == cnt - 1), "R8 done", int'(frame_done_o),
          int'(last && k == cnt - 1));
      if (last && k == cnt - 1)
         chk(sel_o == '0, "R8 sel cleared", int'(sel_o), 0);
      else if (last)
         chk(sel_o == N'(1 << (k + 1)), "R5 sel advanced", int'(sel_o), 1 << (k + 1));
      phi2_i = 1'b0;
      eos_n_i = '1;
      step();
      chk(pix_valid_o == 1'b0, "R4 strobe width", int'(pix_valid_o), 0);
   endtask

   task automatic run_frame(input int req, input int exp_n, input bit poke);
      step();
      arr_cnt_i = CW'(req);
      frame_start_i = 1'b1;
      step();
      frame_start_i = 1'b0;
      chk(start_o[0] == 1'b1, "R2 start0 raised", int'(start_o[0]), 1);
      chk(sel_o == N'(1), "R2 sel first", int'(sel_o), 1);
      for (int k = 0; k < exp_n; k++)
         for (int e = 0; e < E; e++)
            element(k, e, exp_n, poke && k == 1 && e == 1);
      step();
      chk(frame_done_o == 1'b0, "R8 done one cycle", int'(frame_done_o), 0);
      chk(sel_o == '0, "R7 idle sel zero", int'(sel_o), 0);
      chk(start_o == '0, "R6 starts idle", int'(start_o), 0);
   endtask

   initial begin
      repeat (3) step();
      chk(start_o == '0 && sel_o == '0, "R1 reset outputs", int'({start_o, sel_o}), 0);
      chk(pix_valid_o == 1'b0 && frame_done_o == 1'b0, "R1 reset strobes",
          int'({pix_valid_o, frame_done_o}), 0);
      rst_n = 1'b1;
      step();
      chk(sel_o == '0, "R7 sel zero after reset", int'(sel_o), 0);

      for (int v = 0; v < NV; v++)
         run_frame(VEC[v][0], VEC[v][1], VEC[v][2] != 0);

      // R9 clamp for count 0 also checked: only one array scanned above; verify no
      // second-array select appeared by a directed frame of count 0 with end check
      run_frame(0, 1, 0);

      // phi2 edges while idle produce nothing (R4)
      step(); phi2_i = 1'b1;
      step(); phi2_i = 1'b0;
      chk(pix_valid_o == 1'b0, "R4 no strobe idle", int'(pix_valid_o), 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule